// File: doc/BRIEF.md
# Gated 16-Bit Event Timer

A sixteen-bit up-counter exposed to software as two byte-wide count registers, one control register and one status register on a small register bus. The counter can advance on a per-instruction-cycle enable from the core, or on rising edges of an external clock pin. That pin can pass through a synchronizer or go straight to an edge detector. A selectable divider sits in front of the counter and passes one of every 1, 2, 4 or 8 qualifying ticks. An active-low gate pin can pause counting when the control register arms it.

When the count wraps from all ones to zero, a sticky overflow flag is set. Software clears it by writing the status register. A separate enable bit decides whether the flag drives the interrupt request output. Reset clears control and status but leaves the count value untouched.

Top module: `gtmr_core`

## Requirements
- R1: Register map on `bus_addr`: 0 = count bits 7:0, 1 = count bits 15:8, 2 = control, 3 = status. Control bits: bit 0 run, bit 1 external source, bit 2 synchronizer bypass, bit 3 low-frequency oscillator enable (stored only), bits 5:4 divider code, bit 6 gate enable. Control bit 7 always reads 0. Status bit 0 is the overflow flag and bit 1 is the interrupt enable; status bits 7:2 read 0.
- R2: Reset clears control and status to zero and leaves the count value unchanged.
- R3: With run = 0 the count holds, whatever the gate enable, gate pin and clock inputs do.
- R4: With source = 0 and divider code 00, the count advances by one on each clock edge that samples `cyc_en` high. The synchronizer bypass bit and the external pin have no effect in this mode.
- R5: Divider code 00, 01, 10 and 11 advance the count once per 1, 2, 4 and 8 qualifying ticks.
- R6: With run = 1 and gate enable = 1, ticks qualify only on edges where `gate_n_pin` is low. With gate enable = 0 the gate pin is ignored.
- R7: With source = 1 and bypass = 0, a rising pin level first sampled at clock edge e advances the count at edge e+2. A pin held high or falling does not count, and `cyc_en` is ignored.
- R8: With source = 1 and bypass = 1, a rising pin level advances the count at the same edge e that first samples it high.
- R9: An advance from 0xFFFF gives 0x0000 and sets the overflow flag at that edge. The flag stays set until software writes status bit 0 with 0. `ovf_irq` is high exactly when the flag and the interrupt enable are both 1.
- R10: A write to a count byte loads that byte, clears the divider's progress, and takes priority over an advance or overflow in the same cycle. A status write in the same cycle as an overflow decides the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-cycle pulse per instruction cycle (internal tick) |
| tclk_pin | input | 1 | External count clock pin |
| gate_n_pin | input | 1 | Active-low count gate pin |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Register writes and internally timed or bypassed-pin advances show on the read port and on the flag after the very edge that samples them. A synchronized pin edge shows two edges later, and the interrupt output follows the flag in the same cycle. The bench drives inputs at the falling edge. A behavioural model updates at the rising edge using a short history of pin samples, and every output is compared at the next falling edge. The directed checks read the count just after the edge on which each latency says the value is due.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int PS_W   = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

    // control fields, msb first: bit 6 down to bit 0
    typedef struct packed {
        logic            gate_en;
        logic [PS_W-1:0] psel;
        logic            lf_en;
        logic            no_sync;
        logic            src_ext;
        logic            run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t ctrl;
        logic  ovf;
        logic  ovf_ie;
    } regs_t;
endpackage

// File: rtl/gtmr_edge.sv
module gtmr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_sync,
    output logic edge_raw
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   sprev_d, sprev_q;
    logic                   rprev_d, rprev_q;

    always_comb begin
        sync_d[0] = pin;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
        sprev_d = sync_q[SYNC_STAGES-1];
        rprev_d = pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            sprev_q <= 1'b0;
            rprev_q <= 1'b0;
        end else begin
            sync_q  <= sync_d;
            sprev_q <= sprev_d;
            rprev_q <= rprev_d;
        end
    end

    assign edge_sync = sync_q[SYNC_STAGES-1] & ~sprev_q;
    assign edge_raw  = pin & ~rprev_q;
endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = DIV_W'((32'd1 << sel) - 32'd1);
        step  = 1'b0;
        div_d = div_q;
        if (clr) begin
            div_d = '0;
        end else if (tick) begin
            // >= lets a lowered ratio take effect at once
            if (div_q >= lim) begin
                step  = 1'b1;
                div_d = '0;
            end else begin
                div_d = div_q + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/gtmr_core.sv
module gtmr_core
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              tclk_pin,
    input  logic              gate_n_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    regs_t            regs_d, regs_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    logic wr_lo, wr_hi, wr_ctrl, wr_stat, cnt_wr;
    logic edge_sync, edge_raw, src_tick, gate_open, qtick, step;

    assign wr_lo   = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_hi   = bus_wr && (bus_addr == A_CNT_HI);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign cnt_wr  = wr_lo | wr_hi;

    gtmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (tclk_pin),
        .edge_sync (edge_sync),
        .edge_raw  (edge_raw)
    );

    always_comb begin
        if (regs_q.ctrl.src_ext) src_tick = regs_q.ctrl.no_sync ? edge_raw : edge_sync;
        else                     src_tick = cyc_en;
        gate_open = !regs_q.ctrl.gate_en || !gate_n_pin;
        qtick     = src_tick && regs_q.ctrl.run && gate_open;
    end

    gtmr_prescale #(.SEL_W(PS_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_wr),
        .tick  (qtick),
        .sel   (regs_q.ctrl.psel),
        .step  (step)
    );

    always_comb begin
        regs_d = regs_q;
        cnt_d  = cnt_q;
        if (cnt_wr) begin
            if (wr_lo) cnt_d[DATA_W-1:0]     = bus_wdata;
            if (wr_hi) cnt_d[CNT_W-1:DATA_W] = bus_wdata;
        end else if (step) begin
            cnt_d = cnt_q + CNT_W'(1);
            if (&cnt_q) regs_d.ovf = 1'b1;
        end
        if (wr_ctrl) regs_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (wr_stat) begin
            regs_d.ovf    = bus_wdata[0];
            regs_d.ovf_ie = bus_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // count survives reset, so it has no reset term
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    always_comb begin
        unique case (bus_addr)
            A_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
            A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
            A_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, regs_q.ctrl};
            default:  bus_rdata = {{(DATA_W-2){1'b0}}, regs_q.ovf_ie, regs_q.ovf};
        endcase
    end

    assign ovf_flag = regs_q.ovf;
    assign ovf_irq  = regs_q.ovf & regs_q.ovf_ie;
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk
    import gtmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              gate_n_pin,
    input logic [CNT_W-1:0]  cnt,
    input logic [CTRL_W-1:0] ctrl,
    input logic              flag
);
    logic             lo_seen, hi_seen, known, wr_cnt, wr_st;
    logic [CNT_W-1:0] cnt_plus1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_seen <= 1'b0;
            hi_seen <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CNT_LO) lo_seen <= 1'b1;
            if (bus_wr && bus_addr == A_CNT_HI) hi_seen <= 1'b1;
        end
    end

    assign known     = lo_seen & hi_seen;
    assign wr_cnt    = bus_wr && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);
    assign wr_st     = bus_wr && (bus_addr == A_STAT);
    assign cnt_plus1 = cnt + CNT_W'(1);

    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        known && !ctrl[0] && !wr_cnt |=> $stable(cnt));

    a_r6_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        known && ctrl[0] && ctrl[6] && gate_n_pin && !wr_cnt |=> $stable(cnt));

    a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        known && !wr_cnt |=> (cnt == $past(cnt)) || (cnt == $past(cnt_plus1)));

    a_r10_low_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_CNT_LO |=> cnt[DATA_W-1:0] == $past(bus_wdata));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !wr_st |=> flag);

    a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !wr_st && known && cnt != {CNT_W{1'b1}} |=> !flag);
endmodule

bind gtmr_core gtmr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .gate_n_pin (gate_n_pin),
    .cnt        (cnt_q),
    .ctrl       (regs_q.ctrl),
    .flag       (regs_q.ovf)
);

// File: tb/gtmr_core_bench.sv
module gtmr_core_bench;
    logic       clk = 1'b0;
    logic       rst_n, cyc_en, tclk_pin, gate_n_pin, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       ovf_flag, ovf_irq;

    int    nchk = 0;
    int    nfail = 0;
    string cur_req = "R2";

    gtmr_core u_gtmr_core (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .tclk_pin(tclk_pin),
        .gate_n_pin(gate_n_pin), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    always #10 clk = ~clk;

    // behavioural reference
    logic [15:0] m_cnt = 16'h0;
    logic [6:0]  m_ctrl = 7'h0;
    logic        m_flag = 1'b0, m_ien = 1'b0;
    logic [3:0]  m_hist = 4'h0;
    int          m_div = 0;
    bit          m_klo = 0, m_khi = 0;

    always @(posedge clk) begin
        logic src, go, wl, wh;
        if (!rst_n) begin
            m_ctrl = 7'h0; m_flag = 1'b0; m_ien = 1'b0; m_hist = 4'h0; m_div = 0;
        end else begin
            m_hist = {m_hist[2:0], tclk_pin};
            if (m_ctrl[1]) src = m_ctrl[2] ? (m_hist[0] & ~m_hist[1]) : (m_hist[2] & ~m_hist[3]);
            else           src = cyc_en;
            go = src && m_ctrl[0] && (!m_ctrl[6] || !gate_n_pin);
            wl = bus_wr && bus_addr == 2'd0;
            wh = bus_wr && bus_addr == 2'd1;
            if (wl || wh) begin
                if (wl) begin m_cnt[7:0]  = bus_wdata; m_klo = 1; end
                if (wh) begin m_cnt[15:8] = bus_wdata; m_khi = 1; end
                m_div = 0;
            end else if (go) begin
                m_div++;
                if (m_div >= (1 << m_ctrl[5:4])) begin
                    m_div = 0;
                    if (m_cnt == 16'hFFFF) m_flag = 1'b1;
                    m_cnt = m_cnt + 16'd1;
                end
            end
            if (bus_wr && bus_addr == 2'd2) m_ctrl = bus_wdata[6:0];
            if (bus_wr && bus_addr == 2'd3) begin m_flag = bus_wdata[0]; m_ien = bus_wdata[1]; end
        end
    end

    function automatic logic [7:0] mread(input logic [1:0] a);
        case (a)
            2'd0:    return m_cnt[7:0];
            2'd1:    return m_cnt[15:8];
            2'd2:    return {1'b0, m_ctrl};
            default: return {6'b0, m_ien, m_flag};
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk({cur_req, " model flag"}, ovf_flag, m_flag);
        chk({cur_req, " model irq R9"}, ovf_irq, m_flag & m_ien);
        if (bus_addr >= 2'd2 || (bus_addr == 2'd0 && m_klo) || (bus_addr == 2'd1 && m_khi))
            chk({cur_req, " model read"}, bus_rdata, mread(bus_addr));
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #1 v = bus_rdata;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] b;
        rd(2'd0, b); v[7:0] = b;
        rd(2'd1, b); v[15:8] = b;
    endtask

    task automatic load(input logic [15:0] v);
        wr(2'd0, v[7:0]);
        wr(2'd1, v[15:8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired before the run ended");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        rst_n = 0; cyc_en = 0; tclk_pin = 0; gate_n_pin = 1;
        bus_wr = 0; bus_addr = 2'd2; bus_wdata = 8'h0;
        idle(3);
        rst_n = 1;
        tick();

        // R2: reset state, count kept over reset
        cur_req = "R2";
        rd(2'd2, b); chk("R2 ctrl after reset", b, 8'h00);
        rd(2'd3, b); chk("R2 status after reset", b, 8'h00);
        load(16'h1234);
        wr(2'd2, 8'h7E);
        wr(2'd3, 8'h02);
        rst_n = 0; idle(2); rst_n = 1; tick();
        rd16(v); chk("R2 count kept over reset", v, 16'h1234);
        rd(2'd2, b); chk("R2 ctrl cleared", b, 8'h00);
        rd(2'd3, b); chk("R2 status cleared", b, 8'h00);

        // R1: field layout and unused bits
        cur_req = "R1";
        wr(2'd2, 8'hFE);
        rd(2'd2, b); chk("R1 ctrl bit 7 reads 0", b, 8'h7E);
        wr(2'd3, 8'hFF);
        rd(2'd3, b); chk("R1 status upper bits read 0", b, 8'h03);
        chk("R1 irq with flag and enable set", ovf_irq, 1);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h00);

        // R3: off holds count even with gate armed and ticks present
        cur_req = "R3";
        wr(2'd2, 8'h40);
        cyc_en = 1; gate_n_pin = 0;
        for (int i = 0; i < 10; i++) begin tclk_pin = i[0]; tick(); end
        cyc_en = 0; gate_n_pin = 1; tclk_pin = 0;
        rd16(v); chk("R3 count held while off", v, 16'h1234);

        // R4: internal source, bypass bit and pin have no effect
        cur_req = "R4";
        wr(2'd2, 8'h05);
        cyc_en = 1;
        for (int i = 0; i < 6; i++) begin tclk_pin = ~tclk_pin; tick(); end
        cyc_en = 0;
        rd16(v); chk("R4 six internal ticks", v, 16'h123A);
        for (int i = 0; i < 8; i++) begin cyc_en = i[0]; tclk_pin = ~tclk_pin; tick(); end
        cyc_en = 0; tclk_pin = 0;
        rd16(v); chk("R4 every other cycle", v, 16'h123E);

        // R5: divider ratios
        cur_req = "R5";
        for (int ps = 0; ps < 4; ps++) begin
            wr(2'd2, 8'h00);
            load(16'h0000);
            wr(2'd2, 8'((ps << 4) | 1));
            cyc_en = 1; idle(16); cyc_en = 0;
            rd16(v); chk($sformatf("R5 ratio code %0d", ps), v, 16 >> ps);
        end

        // R6: gate
        cur_req = "R6";
        wr(2'd2, 8'h00);
        load(16'h0000);
        wr(2'd2, 8'h41);
        gate_n_pin = 1; cyc_en = 1; idle(8);
        rd16(v); chk("R6 gate high blocks", v, 16'h0000);
        gate_n_pin = 0; idle(5);
        rd16(v); chk("R6 gate low counts", v, 16'h0005);
        gate_n_pin = 1; idle(3);
        rd16(v); chk("R6 gate closed again", v, 16'h0005);
        cyc_en = 0;
        wr(2'd2, 8'h01);
        cyc_en = 1; idle(4); cyc_en = 0;
        rd16(v); chk("R6 gate ignored when disarmed", v, 16'h0009);

        // R7: synchronized external pin, internal ticks ignored
        cur_req = "R7";
        wr(2'd2, 8'h00);
        load(16'h0000);
        wr(2'd2, 8'h03);
        cyc_en = 1; idle(3);
        tclk_pin = 1; tick();
        rd16(v); chk("R7 not at edge e", v, 16'h0000);
        tick();
        rd16(v); chk("R7 not at edge e+1", v, 16'h0000);
        tick();
        rd16(v); chk("R7 count at edge e+2", v, 16'h0001);
        idle(5);
        rd16(v); chk("R7 level held high counts once", v, 16'h0001);
        tclk_pin = 0; idle(5);
        rd16(v); chk("R7 falling edge ignored", v, 16'h0001);
        for (int i = 0; i < 4; i++) begin tclk_pin = 1; tick(); tclk_pin = 0; tick(); end
        idle(4);
        rd16(v); chk("R7 four pulses", v, 16'h0005);
        cyc_en = 0;

        // R8: unsynchronized pin
        cur_req = "R8";
        wr(2'd2, 8'h07);
        idle(2);
        tclk_pin = 1; tick();
        rd16(v); chk("R8 count at sampling edge", v, 16'h0006);
        tclk_pin = 0; tick();
        rd16(v); chk("R8 fall ignored", v, 16'h0006);
        for (int i = 0; i < 3; i++) begin tclk_pin = 1; tick(); tclk_pin = 0; tick(); end
        rd16(v); chk("R8 three pulses", v, 16'h0009);

        // R9: overflow flag and interrupt
        cur_req = "R9";
        wr(2'd2, 8'h00);
        load(16'hFFFE);
        wr(2'd2, 8'h01);
        cyc_en = 1; tick(); cyc_en = 0;
        rd16(v); chk("R9 reaches 0xFFFF", v, 16'hFFFF);
        chk("R9 no flag before wrap", ovf_flag, 0);
        cyc_en = 1; tick(); cyc_en = 0;
        rd16(v); chk("R9 wraps to zero", v, 16'h0000);
        chk("R9 flag set on wrap", ovf_flag, 1);
        chk("R9 irq masked", ovf_irq, 0);
        idle(3);
        chk("R9 flag sticky", ovf_flag, 1);
        wr(2'd3, 8'h02);
        chk("R9 flag cleared by software", ovf_flag, 0);
        load(16'hFFFF);
        cyc_en = 1; tick(); cyc_en = 0;
        chk("R9 irq raised when enabled", ovf_irq, 1);
        wr(2'd3, 8'h02);
        chk("R9 irq drops with flag", ovf_irq, 0);

        // R10: write priority and divider clear
        cur_req = "R10";
        wr(2'd3, 8'h00);
        load(16'hFFFF);
        cyc_en = 1; wr(2'd0, 8'h55); cyc_en = 0;
        rd16(v); chk("R10 byte write beats advance", v, 16'hFF55);
        chk("R10 no overflow under write", ovf_flag, 0);
        wr(2'd0, 8'hFF);
        cyc_en = 1; wr(2'd3, 8'h00); cyc_en = 0;
        rd16(v); chk("R10 wrap alongside status write", v, 16'h0000);
        chk("R10 status write decides flag", ovf_flag, 0);
        wr(2'd2, 8'h21);
        load(16'h0000);
        cyc_en = 1; idle(3); cyc_en = 0;
        wr(2'd0, 8'h10);
        cyc_en = 1; idle(3); cyc_en = 0;
        rd16(v); chk("R10 divider restarted by write", v, 16'h0010);
        cyc_en = 1; tick(); cyc_en = 0;
        rd16(v); chk("R10 fourth tick after write", v, 16'h0011);

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule